// File: doc/BRIEF.md
# Eight-Level Interrupt Priority Resolver with End-of-Interrupt Control

This block keeps the request, in-service and mask-gated arbitration state of an eight-input interrupt controller. Raw request lines are captured into a request register, either on a rising edge or by following the line level. Each cycle a rotating-priority picker chooses the best unmasked pending request. The block offers that request to the processor only when its priority is strictly above every level already in service. In special mask mode it offers the request without that restriction.

An external acknowledge sequencer uses the block through strobes. `ack_take` moves the offered level from pending into service. `ack_aeoi` ends service of a level automatically at the close of an acknowledge. End-of-interrupt and priority commands arrive as a 3-bit operation code with a 3-bit level operand. These commands clear in-service bits and move the lowest-priority pointer, so priority can rotate. A two-state mode register selects what happens when service ends automatically. In `AEOI_FIXED` the pointer stays put. In `AEOI_ROTATE` the ended level becomes the lowest priority. The transitions are `AEOI_FIXED -> AEOI_ROTATE` on operation 100 and `AEOI_ROTATE -> AEOI_FIXED` on operation 000. Every other input leaves the mode where it is.

Top module: `eoi_resolver`

## Requirements
- R1: After reset the request and in-service registers are zero, `int_valid` is low, the rotate-on-automatic-end mode is off, and the lowest-priority pointer is 7, so level 0 has the highest priority.
- R2: With `level_mode` low, a rising edge on a request line sets its request bit one clock later. A line held high does not set the bit again after it has been cleared. With `level_mode` high, each request bit takes the value of its line at every clock. In either mode, a clear caused by `ack_take` wins in the cycle it happens.
- R3: A request whose `mask` bit is 1 is never offered, even in special mask mode. Masking does not change the request register.
- R4: Priority runs from the level just above the lowest-priority pointer, (pointer+1) mod 8, upward with wraparound. `int_level` gives the highest-priority unmasked pending level.
- R5: With `special_mask` low, `int_valid` is high only when the winning request has strictly higher priority than every set in-service bit.
- R6: With `special_mask` high, set in-service bits do not block any request.
- R7: `ack_take` while `int_valid` is high sets the in-service bit of `int_level` and clears its request bit on the next clock.
- R8: Operation 001 clears the highest-priority set in-service bit.
- R9: Operation 011 clears the in-service bit named by `cmd_level`.
- R10: Operation 101 clears the highest-priority set in-service bit and makes that level the lowest priority. Operation 111 clears the in-service bit at `cmd_level` and makes `cmd_level` the lowest priority. Operation 110 only makes `cmd_level` the lowest priority.
- R11: Operation 100 switches to rotate-on-automatic-end mode and operation 000 switches it off. `ack_aeoi` clears the in-service bit at `aeoi_level`, and only in that mode does it make `aeoi_level` the lowest priority.
- R12: Operation 010 is reserved and changes neither the in-service register, the pointer nor the offered request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_lines | input | 8 | Raw interrupt request lines |
| level_mode | input | 1 | 1 = level sensing, 0 = rising-edge sensing |
| mask | input | 8 | Per-level mask, 1 = masked |
| special_mask | input | 1 | 1 = in-service levels do not block requests |
| cmd_valid | input | 1 | Command strobe for one cycle |
| cmd_code | input | 3 | End-of-interrupt / priority operation code |
| cmd_level | input | 3 | Level operand of the command |
| ack_take | input | 1 | Sequencer moves the offered level into service |
| ack_aeoi | input | 1 | Sequencer ends service of `aeoi_level` automatically |
| aeoi_level | input | 3 | Level whose service ends automatically |
| int_valid | output | 1 | A request may interrupt now |
| int_level | output | 3 | Level of the offered request |
| irr | output | 8 | Request register readback |
| isr | output | 8 | In-service register readback |

## Verification
The temporal assertions assume that the sequencer never raises `cmd_valid` in the same cycle as `ack_take` or `ack_aeoi`. Each property also names the strobes it excludes in its antecedent. The stimulus issues every command, acknowledge and automatic end in a cycle of its own, and it applies `ack_aeoi` only to a level that is in service. Request lines change only on falling clock edges and never in a cycle that acknowledges the same level. This keeps edge capture and acknowledge clearing from competing for one bit.

// File: rtl/pri_pkg.sv
package pri_pkg;

    typedef enum logic [2:0] {
        OP_AEOI_ROT_OFF = 3'b000,
        OP_EOI_ANY      = 3'b001,
        OP_RESERVED     = 3'b010,
        OP_EOI_ONE      = 3'b011,
        OP_AEOI_ROT_ON  = 3'b100,
        OP_EOI_ANY_ROT  = 3'b101,
        OP_SET_LOWEST   = 3'b110,
        OP_EOI_ONE_ROT  = 3'b111
    } eoi_op_t;

    typedef enum logic {
        AEOI_FIXED,
        AEOI_ROTATE
    } aeoi_mode_t;

endpackage

// File: rtl/req_capture.sv
module req_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic         level_mode,
    input  logic [N-1:0] take_clr,
    output logic [N-1:0] irr
);

    logic [N-1:0] prev_q;
    logic [N-1:0] irr_q;
    logic [N-1:0] irr_d;
    logic [N-1:0] rise;

    always_comb begin
        rise = lines & ~prev_q;
        if (level_mode) begin
            irr_d = lines & ~take_clr;
        end else begin
            irr_d = (irr_q | rise) & ~take_clr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= lines;
            irr_q  <= irr_d;
        end
    end

    assign irr = irr_q;

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && take_clr == '0) |=> ((irr & $past(irr)) == $past(irr))); // R2

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_clr != '0) |=> ((irr & $past(take_clr)) == '0)); // R2

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] bits,
    input  logic [W-1:0] low_lvl,
    output logic         found,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rank
);

    logic [N-1:0] rot;

    for (genvar k = 0; k < N; k++) begin : g_rot
        assign rot[k] = bits[W'(low_lvl + W'(1) + W'(k))];
    end

    always_comb begin
        found = 1'b0;
        lvl   = '0;
        rank  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (rot[k]) begin
                found = 1'b1;
                rank  = W'(k);
                lvl   = W'(low_lvl + W'(1) + W'(k));
            end
        end
    end

endmodule

// File: rtl/eoi_resolver.sv
module eoi_resolver
    import pri_pkg::*;
#(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_lines,
    input  logic         level_mode,
    input  logic [N-1:0] mask,
    input  logic         special_mask,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_code,
    input  logic [W-1:0] cmd_level,
    input  logic         ack_take,
    input  logic         ack_aeoi,
    input  logic [W-1:0] aeoi_level,
    output logic         int_valid,
    output logic [W-1:0] int_level,
    output logic [N-1:0] irr,
    output logic [N-1:0] isr
);

    aeoi_mode_t   mode_q, mode_d;
    logic [W-1:0] low_q, low_d;
    logic [N-1:0] isr_q, isr_d;
    logic [N-1:0] set_vec, clr_vec, take_clr;
    logic [N-1:0] irr_w;
    logic         rq_found, sv_found, win, take;
    logic [W-1:0] rq_lvl, rq_rank, sv_lvl, sv_rank;

    function automatic logic [N-1:0] one_at(input logic [W-1:0] l);
        logic [N-1:0] v;
        v    = '0;
        v[l] = 1'b1;
        return v;
    endfunction

    req_capture #(.N(N)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines      (req_lines),
        .level_mode (level_mode),
        .take_clr   (take_clr),
        .irr        (irr_w)
    );

    prio_pick #(.N(N)) u_req_pick (
        .bits    (irr_w & ~mask),
        .low_lvl (low_q),
        .found   (rq_found),
        .lvl     (rq_lvl),
        .rank    (rq_rank)
    );

    prio_pick #(.N(N)) u_svc_pick (
        .bits    (isr_q),
        .low_lvl (low_q),
        .found   (sv_found),
        .lvl     (sv_lvl),
        .rank    (sv_rank)
    );

    always_comb begin
        win  = rq_found && (special_mask || !sv_found || (rq_rank < sv_rank));
        take = ack_take && win;
        take_clr = take ? one_at(rq_lvl) : '0;
    end

    always_comb begin
        mode_d  = mode_q;
        low_d   = low_q;
        set_vec = take_clr;
        clr_vec = '0;
        if (ack_aeoi) begin
            clr_vec = clr_vec | one_at(aeoi_level);
            if (mode_q == AEOI_ROTATE) begin
                low_d = aeoi_level;
            end
        end
        if (cmd_valid) begin
            unique case (eoi_op_t'(cmd_code))
                OP_AEOI_ROT_OFF: mode_d = AEOI_FIXED;
                OP_AEOI_ROT_ON:  mode_d = AEOI_ROTATE;
                OP_EOI_ANY: begin
                    if (sv_found) clr_vec = clr_vec | one_at(sv_lvl);
                end
                OP_EOI_ANY_ROT: begin
                    if (sv_found) begin
                        clr_vec = clr_vec | one_at(sv_lvl);
                        low_d   = sv_lvl;
                    end
                end
                OP_EOI_ONE:     clr_vec = clr_vec | one_at(cmd_level);
                OP_EOI_ONE_ROT: begin
                    clr_vec = clr_vec | one_at(cmd_level);
                    low_d   = cmd_level;
                end
                OP_SET_LOWEST:  low_d = cmd_level;
                OP_RESERVED:    ;
            endcase
        end
        isr_d = (isr_q | set_vec) & ~clr_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= AEOI_FIXED;
            low_q  <= W'(N - 1);
            isr_q  <= '0;
        end else begin
            mode_q <= mode_d;
            low_q  <= low_d;
            isr_q  <= isr_d;
        end
    end

    always_comb begin
        int_valid = win;
        int_level = rq_lvl;
        irr       = irr_w;
        isr       = isr_q;
    end

    AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |-> (irr[int_level] && !mask[int_level])); // R3

    AST_NEST_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        (int_valid && !special_mask) |-> !isr[int_level]); // R5

    AST_TAKE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && int_valid && !cmd_valid && !ack_aeoi)
        |=> (isr[$past(int_level)] && !irr[$past(int_level)])); // R7

    AST_SPEC_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'b011 && !ack_take && !ack_aeoi)
        |=> !isr[$past(cmd_level)]); // R9

    AST_SET_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'b110 && !ack_take && !ack_aeoi)
        |=> (low_q == $past(cmd_level) && $stable(isr))); // R10

    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'b010 && !ack_take && !ack_aeoi)
        |=> ($stable(isr) && $stable(low_q))); // R12

endmodule

// File: tb/eoi_resolver_tb.sv
module eoi_resolver_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_lines = '0;
    logic       level_mode = 1'b0;
    logic [7:0] mask = '0;
    logic       special_mask = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = '0;
    logic [2:0] cmd_level = '0;
    logic       ack_take = 1'b0;
    logic       ack_aeoi = 1'b0;
    logic [2:0] aeoi_level = '0;
    logic       int_valid;
    logic [2:0] int_level;
    logic [7:0] irr;
    logic [7:0] isr;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    logic [7:0] m_irr, m_isr, m_prev;
    int         m_lp;
    bit         m_rot;

    always #5 clk = ~clk;

    eoi_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .req_lines(req_lines), .level_mode(level_mode),
        .mask(mask), .special_mask(special_mask), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_level(cmd_level), .ack_take(ack_take),
        .ack_aeoi(ack_aeoi), .aeoi_level(aeoi_level), .int_valid(int_valid),
        .int_level(int_level), .irr(irr), .isr(isr)
    );

    function automatic int rk(int i, int lp);
        return (i - lp - 1 + 16) % 8;
    endfunction

    function automatic void top_of(input logic [7:0] v, input int lp,
                                   output bit f, output int l, output int r);
        f = 0; l = 0; r = 99;
        for (int i = 0; i < 8; i++) begin
            if (v[i] && rk(i, lp) < r) begin
                f = 1; l = i; r = rk(i, lp);
            end
        end
    endfunction

    function automatic void m_win(output bit v, output int l);
        bit rf, sf;
        int rl, rr, sl, sr;
        top_of(m_irr & ~mask, m_lp, rf, rl, rr);
        top_of(m_isr, m_lp, sf, sl, sr);
        v = rf && (special_mask || !sf || rr < sr);
        l = rl;
    endfunction

    always @(posedge clk) begin : model_upd
        bit v, sf;
        int l, sl, sr, nlp;
        bit nrot;
        logic [7:0] nirr, nisr;
        if (!rst_n) begin
            m_irr = '0; m_isr = '0; m_prev = '0; m_lp = 7; m_rot = 0;
        end else begin
            m_win(v, l);
            top_of(m_isr, m_lp, sf, sl, sr);
            nisr = m_isr; nlp = m_lp; nrot = m_rot;
            if (ack_take && v) nisr[l] = 1'b1;
            if (ack_aeoi) begin
                nisr[aeoi_level] = 1'b0;
                if (m_rot) nlp = aeoi_level;
            end
            if (cmd_valid) begin
                case (cmd_code)
                    3'd0: nrot = 0;
                    3'd4: nrot = 1;
                    3'd1: if (sf) nisr[sl] = 1'b0;
                    3'd5: if (sf) begin nisr[sl] = 1'b0; nlp = sl; end
                    3'd3: nisr[cmd_level] = 1'b0;
                    3'd7: begin nisr[cmd_level] = 1'b0; nlp = cmd_level; end
                    3'd6: nlp = cmd_level;
                    default: ;
                endcase
            end
            for (int i = 0; i < 8; i++) begin
                if (level_mode) nirr[i] = req_lines[i];
                else nirr[i] = m_irr[i] | (req_lines[i] & ~m_prev[i]);
                if (ack_take && v && l == i) nirr[i] = 1'b0;
            end
            m_prev = req_lines;
            m_irr = nirr; m_isr = nisr; m_lp = nlp; m_rot = nrot;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin : per_cycle
        bit v;
        int l;
        #2;
        if (rst_n && !done) begin
            m_win(v, l);
            chk("R2 cycle irr", irr, m_irr);
            chk("R7 cycle isr", isr, m_isr);
            chk("R4 cycle int_valid", int_valid, v);
            if (v) chk("R4 cycle int_level", int_level, l);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_cmd(input logic [2:0] code, input logic [2:0] lvl);
        cmd_valid = 1'b1; cmd_code = code; cmd_level = lvl;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic do_ack();
        ack_take = 1'b1;
        tick();
        ack_take = 1'b0;
    endtask

    task automatic do_aeoi(input logic [2:0] lvl);
        ack_aeoi = 1'b1; aeoi_level = lvl;
        tick();
        ack_aeoi = 1'b0;
    endtask

    task automatic pulse_lines(input logic [7:0] v);
        req_lines = v;
        tick();
        req_lines = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset int_valid", int_valid, 0);
        rst_n = 1'b1;
        #1;
        chk("R1 reset irr", irr, 8'h00);
        chk("R1 reset isr", isr, 8'h00);
        chk("R1 reset int_valid after release", int_valid, 0);

        pulse_lines(8'h81);
        chk("R1 level 0 beats level 7", int_level, 0);
        chk("R2 edge sets irr", irr, 8'h81);

        do_ack();
        chk("R7 ack sets isr", isr, 8'h01);
        chk("R7 ack clears irr", irr, 8'h80);
        chk("R5 lower level blocked", int_valid, 0);

        do_cmd(3'b001, 3'd0);
        chk("R8 non-specific eoi", isr, 8'h00);
        chk("R8 level 7 now offered", int_level, 7);

        do_ack();
        chk("R7 ack level 7", isr, 8'h80);

        req_lines = 8'h08;
        tick();
        chk("R5 higher level nests", int_level, 3);
        chk("R5 higher level valid", int_valid, 1);
        do_ack();
        chk("R2 held edge line not re-latched", irr, 8'h00);
        req_lines = '0;
        tick();
        chk("R7 nested isr", isr, 8'h88);

        do_cmd(3'b011, 3'd7);
        chk("R9 specific eoi level 7", isr, 8'h08);

        pulse_lines(8'h40);
        chk("R5 level 6 blocked by 3", int_valid, 0);
        special_mask = 1'b1;
        #1;
        chk("R6 special mask valid", int_valid, 1);
        chk("R6 special mask level", int_level, 6);
        mask = 8'h40;
        #1;
        chk("R3 masked never offered", int_valid, 0);
        chk("R3 mask keeps irr", irr, 8'h40);
        mask = '0;
        special_mask = 1'b0;

        do_cmd(3'b001, 3'd0);
        chk("R8 clears level 3", isr, 8'h00);

        do_cmd(3'b110, 3'd6);
        chk("R10 set lowest keeps isr", isr, 8'h00);
        pulse_lines(8'h80);
        chk("R10 level 7 highest after set", int_level, 7);

        do_ack();
        chk("R5 level 6 blocked by 7", int_valid, 0);
        do_cmd(3'b101, 3'd0);
        chk("R10 rotate non-specific clears", isr, 8'h00);
        pulse_lines(8'h01);
        chk("R10 rotate made 7 lowest", int_level, 0);

        do_ack();
        do_cmd(3'b111, 3'd0);
        chk("R10 rotate specific clears", isr, 8'h00);
        pulse_lines(8'h01);
        chk("R10 level 0 now lowest", int_level, 6);

        do_ack();
        chk("R7 ack level 6", isr, 8'h40);
        do_cmd(3'b010, 3'd0);
        chk("R12 reserved isr", isr, 8'h40);
        chk("R12 reserved irr", irr, 8'h01);
        chk("R12 reserved valid", int_valid, 0);

        do_cmd(3'b011, 3'd6);
        chk("R12 pointer untouched", int_level, 0);

        do_cmd(3'b100, 3'd0);
        pulse_lines(8'h08);
        chk("R4 wrap order", int_level, 3);
        do_ack();
        do_aeoi(3'd3);
        chk("R11 auto end clears", isr, 8'h00);
        pulse_lines(8'h14);
        chk("R11 rotate on auto end", int_level, 4);

        do_cmd(3'b000, 3'd0);
        do_ack();
        do_aeoi(3'd4);
        chk("R11 fixed auto end clears", isr, 8'h00);
        pulse_lines(8'h10);
        chk("R11 fixed mode keeps pointer", int_level, 4);

        level_mode = 1'b1;
        tick();
        chk("R2 level follows low line", irr, 8'h00);
        req_lines = 8'h02;
        tick();
        chk("R2 level follows high line", irr, 8'h02);
        req_lines = 8'h00;
        tick();
        chk("R2 level drops with line", irr, 8'h00);

        tick();
        finish_run();
    end

endmodule